// File: doc/BRIEF.md
# Processor Hotplug Status Register Block

This block keeps the insertion state of a fixed number of processor slots and makes it visible to firmware through a small register window. Each slot has a present bit and a pending-insert bit. Firmware first points the block at one slot by writing an index into the slot selector. It then reads that slot's flags and drops the pending-insert bit by writing a one to it. Side-band plug inputs report that a processor has arrived. A processor that arrives while the system runs (a hot insert) also sets the pending bit and pulses an event output. A processor that is there from the start sets only its present bit.

To find pending work, firmware writes the "next event" command (code 0). A two-state machine then walks the slots one per clock, starting at the current selector and wrapping from the last slot back to slot 0. It stops at the first slot whose insert is pending and moves the selector there. If it has looked at every slot once without a hit, it leaves the selector where it was. While the walk runs, `busy` is high and every bus access is ignored. Firmware reads the result through the data register.

The machine has two states, ST_IDLE and ST_SCAN. It goes from ST_IDLE to ST_SCAN when a command 0 write is accepted. It stays in ST_SCAN while the slot under test has no pending insert and slots remain to be checked. It goes from ST_SCAN back to ST_IDLE on a hit, or after the last unvisited slot has been checked.

The bus addresses dwords: `bus_word` 0 is the selector, 1 is the control dword, 2 is the data dword and 3 is unused. In the control dword, byte lane 0 holds the flags and byte lane 1 holds the command. Byte enables select the lanes, with lane 0 being the least significant byte.

Top module: `hp_hotplug_regs`

## Requirements
- R1: After reset the selector is 0, the stored command is 0, every present and pending bit is 0, `busy` is 0 and `hp_event` is 0.
- R2: A read request accepted while `busy` is low gives `bus_rvalid` high, with `bus_rdata` valid, in the next cycle. The control dword reads with bit 0 = present and bit 1 = pending of the selected slot, and every other bit reads 0 (the command lane reads 0). The selector dword reads 0.
- R3: A control write with lane 0 enabled and wdata bit 1 = 1 clears the selected slot's pending bit. If bit 1 is 0, nothing changes. The present bit is never changed by a bus write.
- R4: A plug with `plug_hot`=1 sets that slot's present and pending bits and raises `hp_event` for exactly the next cycle. This happens even if the slot is already pending. A plug with `plug_hot`=0 sets only the present bit and raises no event.
- R5: A command write of code 0 (lane 1) starts a scan at the selector, wrapping from N_SLOTS-1 to 0. The selector moves to the first pending slot. `busy` stays high for d+1 cycles, where d is the distance from the start slot to that hit.
- R6: If no slot is pending, the scan keeps `busy` high for N_SLOTS cycles and leaves the selector unchanged.
- R7: A command code at or above CMD_COUNT is ignored: the stored command is unchanged and no scan starts.
- R8: While the stored command is 0 and the selector is below N_SLOTS, the data dword reads the selector value.
- R9: With the selector at or above N_SLOTS, control and data reads return 0, and control writes (flag clear and command) are ignored. Selector writes are still accepted.
- R10: While `busy` is high, bus requests are ignored: no `bus_rvalid`, and no register changes.
- R11: Selector writes update only the byte lanes enabled in `bus_be`, with lane 0 as the least significant byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | input | 1 | Access request, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_word | input | 2 | Dword index inside the window |
| bus_be | input | 4 | Byte-lane enables, lane 0 least significant |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid |
| busy | output | 1 | Scan in progress, accesses ignored |
| plug_valid | input | 1 | Processor arrival strobe |
| plug_hot | input | 1 | 1 = hot insert, 0 = present from start |
| plug_slot | input | SLOT_W | Slot index of the arrival |
| hp_event | output | 1 | One-cycle hotplug event pulse |

## Verification
Read data arrives one cycle after the request cycle, and `hp_event` follows a plug strobe by one cycle. `busy` rises one cycle after a command write and stays high for d+1 cycles, or for N_SLOTS cycles when nothing is pending. The bench drives and samples on the falling edge. Each read pushes its expected value into a queue, and a monitor pops and compares on every `bus_rvalid`. A `bus_rvalid` with an empty queue is a failure, which is how accesses ignored during a scan are caught. The bench measures the `busy` width by counting falling edges, and compares it against the hit distance it computes itself.

// File: rtl/hp_pkg.sv
package hp_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SCAN = 1'b1
    } scan_state_t;

    localparam logic [1:0] WORD_SEL  = 2'd0;
    localparam logic [1:0] WORD_CTL  = 2'd1;
    localparam logic [1:0] WORD_DATA = 2'd2;

    localparam logic [7:0] CMD_NEXT_EVENT = 8'd0;
    localparam int FLAG_PRESENT_BIT = 0;
    localparam int FLAG_PENDING_BIT = 1;
endpackage

// File: rtl/hp_slot_bank.sv
module hp_slot_bank #(
    parameter int N_SLOTS = 8,
    parameter int SLOT_W  = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               plug_valid,
    input  logic               plug_hot,
    input  logic [SLOT_W-1:0]  plug_slot,
    input  logic               clr_en,
    input  logic [SLOT_W-1:0]  clr_idx,
    output logic [N_SLOTS-1:0] present,
    output logic [N_SLOTS-1:0] pending,
    output logic               hp_event
);
    logic slot_in_range;
    assign slot_in_range = 32'(plug_slot) < N_SLOTS;

    for (genvar g = 0; g < N_SLOTS; g++) begin : g_slot
        logic hit_plug;
        logic hit_clr;
        assign hit_plug = plug_valid && (plug_slot == SLOT_W'(g));
        assign hit_clr  = clr_en && (clr_idx == SLOT_W'(g));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                present[g] <= 1'b0;
                pending[g] <= 1'b0;
            end else begin
                if (hit_plug) begin
                    present[g] <= 1'b1;
                end
                // a hot insert wins over a simultaneous clear
                if (hit_plug && plug_hot) begin
                    pending[g] <= 1'b1;
                end else if (hit_clr) begin
                    pending[g] <= 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hp_event <= 1'b0;
        end else begin
            hp_event <= plug_valid && plug_hot && slot_in_range;
        end
    end
endmodule

// File: rtl/hp_scan_fsm.sv
module hp_scan_fsm
    import hp_pkg::*;
#(
    parameter int N_SLOTS = 8,
    parameter int SLOT_W  = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [SLOT_W-1:0]  start_idx,
    input  logic [N_SLOTS-1:0] pending,
    output logic               busy,
    output logic               found,
    output logic [SLOT_W-1:0]  found_idx
);
    localparam int CNT_W = $clog2(N_SLOTS + 1);
    localparam logic [SLOT_W-1:0] LAST_IDX = SLOT_W'(N_SLOTS - 1);

    scan_state_t state, next_state;
    logic [SLOT_W-1:0] iter;
    logic [CNT_W-1:0]  steps;
    logic hit;
    logic lap_done;

    assign hit      = pending[iter];
    assign lap_done = steps == CNT_W'(N_SLOTS - 1);

    always_comb begin
        next_state = state;
        unique case (state)
            ST_IDLE: if (start) next_state = ST_SCAN;
            ST_SCAN: if (hit || lap_done) next_state = ST_IDLE;
            default: next_state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= next_state;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            iter  <= '0;
            steps <= '0;
        end else if (state == ST_IDLE && start) begin
            iter  <= start_idx;
            steps <= '0;
        end else if (state == ST_SCAN) begin
            iter  <= (iter == LAST_IDX) ? '0 : iter + 1'b1;
            steps <= steps + 1'b1;
        end
    end

    always_comb begin
        busy      = 1'b0;
        found     = 1'b0;
        found_idx = iter;
        unique case (state)
            ST_IDLE: busy = 1'b0;
            ST_SCAN: begin
                busy  = 1'b1;
                found = hit;
            end
            default: busy = 1'b0;
        endcase
    end
endmodule

// File: rtl/hp_reg_file.sv
module hp_reg_file
    import hp_pkg::*;
#(
    parameter int N_SLOTS   = 8,
    parameter int SLOT_W    = 3,
    parameter int CMD_COUNT = 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_req,
    input  logic               bus_we,
    input  logic [1:0]         bus_word,
    input  logic [3:0]         bus_be,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    output logic               bus_rvalid,
    input  logic               busy,
    input  logic [N_SLOTS-1:0] present,
    input  logic [N_SLOTS-1:0] pending,
    input  logic               found,
    input  logic [SLOT_W-1:0]  found_idx,
    output logic               clr_en,
    output logic [SLOT_W-1:0]  clr_idx,
    output logic               scan_start,
    output logic [SLOT_W-1:0]  scan_idx
);
    logic [31:0] selector;
    logic [7:0]  command;
    logic        acc;
    logic        sel_ok;
    logic [SLOT_W-1:0] sel_idx;
    logic        ctl_wr;
    logic        cmd_ok;
    logic [31:0] rd_word;

    assign acc     = bus_req && !busy;
    assign sel_ok  = selector < 32'(N_SLOTS);
    assign sel_idx = selector[SLOT_W-1:0];
    assign ctl_wr  = acc && bus_we && (bus_word == WORD_CTL) && sel_ok;
    assign clr_en  = ctl_wr && bus_be[0] && bus_wdata[FLAG_PENDING_BIT];
    assign clr_idx = sel_idx;
    assign cmd_ok  = ctl_wr && bus_be[1] && (32'(bus_wdata[15:8]) < CMD_COUNT);
    assign scan_start = cmd_ok && (bus_wdata[15:8] == CMD_NEXT_EVENT);
    assign scan_idx   = sel_idx;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            selector <= '0;
        end else if (acc && bus_we && bus_word == WORD_SEL) begin
            for (int b = 0; b < 4; b++) begin
                if (bus_be[b]) selector[8*b +: 8] <= bus_wdata[8*b +: 8];
            end
        end else if (found) begin
            selector <= 32'(found_idx);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            command <= CMD_NEXT_EVENT;
        end else if (cmd_ok) begin
            command <= bus_wdata[15:8];
        end
    end

    always_comb begin
        rd_word = '0;
        case (bus_word)
            WORD_CTL: if (sel_ok) begin
                rd_word[FLAG_PRESENT_BIT] = present[sel_idx];
                rd_word[FLAG_PENDING_BIT] = pending[sel_idx];
            end
            WORD_DATA: if (sel_ok && command == CMD_NEXT_EVENT) rd_word = selector;
            default: rd_word = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rvalid <= 1'b0;
            bus_rdata  <= '0;
        end else begin
            bus_rvalid <= acc && !bus_we;
            if (acc && !bus_we) bus_rdata <= rd_word;
        end
    end
endmodule

// File: rtl/hp_hotplug_regs.sv
module hp_hotplug_regs #(
    parameter int N_SLOTS   = 8,
    parameter int CMD_COUNT = 1,
    parameter int SLOT_W    = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [1:0]        bus_word,
    input  logic [3:0]        bus_be,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              bus_rvalid,
    output logic              busy,
    input  logic              plug_valid,
    input  logic              plug_hot,
    input  logic [SLOT_W-1:0] plug_slot,
    output logic              hp_event
);
    logic [N_SLOTS-1:0] present;
    logic [N_SLOTS-1:0] pending;
    logic               clr_en;
    logic [SLOT_W-1:0]  clr_idx;
    logic               scan_start;
    logic [SLOT_W-1:0]  scan_idx;
    logic               scan_found;
    logic [SLOT_W-1:0]  scan_found_idx;

    hp_slot_bank #(.N_SLOTS(N_SLOTS), .SLOT_W(SLOT_W)) bank_i (
        .clk(clk), .rst_n(rst_n),
        .plug_valid(plug_valid), .plug_hot(plug_hot), .plug_slot(plug_slot),
        .clr_en(clr_en), .clr_idx(clr_idx),
        .present(present), .pending(pending), .hp_event(hp_event)
    );

    hp_scan_fsm #(.N_SLOTS(N_SLOTS), .SLOT_W(SLOT_W)) scan_i (
        .clk(clk), .rst_n(rst_n),
        .start(scan_start), .start_idx(scan_idx), .pending(pending),
        .busy(busy), .found(scan_found), .found_idx(scan_found_idx)
    );

    hp_reg_file #(.N_SLOTS(N_SLOTS), .SLOT_W(SLOT_W), .CMD_COUNT(CMD_COUNT)) regs_i (
        .clk(clk), .rst_n(rst_n),
        .bus_req(bus_req), .bus_we(bus_we), .bus_word(bus_word),
        .bus_be(bus_be), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
        .busy(busy), .present(present), .pending(pending),
        .found(scan_found), .found_idx(scan_found_idx),
        .clr_en(clr_en), .clr_idx(clr_idx),
        .scan_start(scan_start), .scan_idx(scan_idx)
    );
endmodule

// File: rtl/hp_hotplug_regs_chk.sv
module hp_hotplug_regs_chk #(
    parameter int N_SLOTS = 8,
    parameter int SLOT_W  = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic               bus_req,
    input logic               bus_we,
    input logic               bus_rvalid,
    input logic               busy,
    input logic               plug_valid,
    input logic               plug_hot,
    input logic [SLOT_W-1:0]  plug_slot,
    input logic               hp_event,
    input logic [N_SLOTS-1:0] pending,
    input logic               found,
    input logic [SLOT_W-1:0]  found_idx
);
    logic hot_ok;
    assign hot_ok = plug_valid && plug_hot && (32'(plug_slot) < N_SLOTS);

    AST_EVENT_ON_HOT: assert property (@(posedge clk) disable iff (!rst_n)
        hot_ok |=> hp_event); // R4
    AST_EVENT_ONLY_HOT: assert property (@(posedge clk) disable iff (!rst_n)
        !hot_ok |=> !hp_event); // R4
    AST_PEND_ON_HOT: assert property (@(posedge clk) disable iff (!rst_n)
        hot_ok |=> pending[$past(plug_slot)]); // R4
    AST_READ_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_we && !busy) |=> bus_rvalid); // R2
    AST_BUSY_NO_RVALID: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && busy) |=> !bus_rvalid); // R10
    AST_FOUND_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        found |-> pending[found_idx]); // R5
    AST_FOUND_ENDS_SCAN: assert property (@(posedge clk) disable iff (!rst_n)
        found |=> !busy); // R5
endmodule

bind hp_hotplug_regs hp_hotplug_regs_chk #(.N_SLOTS(N_SLOTS), .SLOT_W(SLOT_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
    .bus_rvalid(bus_rvalid), .busy(busy), .plug_valid(plug_valid),
    .plug_hot(plug_hot), .plug_slot(plug_slot), .hp_event(hp_event),
    .pending(pending), .found(scan_found), .found_idx(scan_found_idx)
);

// File: tb/hp_hotplug_regs_tb_top.sv
`timescale 1ns/1ps
module hp_hotplug_regs_tb_top;
    localparam int N_SLOTS = 8;
    localparam int SLOT_W  = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_req = 1'b0;
    logic        bus_we = 1'b0;
    logic [1:0]  bus_word = 2'd0;
    logic [3:0]  bus_be = 4'h0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_rvalid;
    logic        busy;
    logic        plug_valid = 1'b0;
    logic        plug_hot = 1'b0;
    logic [SLOT_W-1:0] plug_slot = '0;
    logic        hp_event;

    int checks = 0;
    int errors = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    hp_hotplug_regs #(.N_SLOTS(N_SLOTS)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
        .bus_word(bus_word), .bus_be(bus_be), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid), .busy(busy),
        .plug_valid(plug_valid), .plug_hot(plug_hot), .plug_slot(plug_slot),
        .hp_event(hp_event)
    );

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // monitor: pops the scoreboard on every returned read
    always @(negedge clk) begin
        if (rst_n && bus_rvalid) begin
            if (exp_q.size() == 0) begin
                checks++;
                errors++;
                $display("FAIL R10: actual unexpected rvalid data %0h expected no rvalid", bus_rdata);
            end else begin
                check(bus_rdata, exp_q.pop_front(), tag_q.pop_front());
            end
        end
    end

    task automatic bus_write(input logic [1:0] w, input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b1; bus_word = w; bus_be = be; bus_wdata = d;
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] w, input logic [31:0] exp, input string tag);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b0; bus_word = w; bus_be = 4'hf;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        bus_req = 1'b0;
    endtask

    task automatic plug(input logic [SLOT_W-1:0] s, input logic hot, input string tag);
        @(negedge clk);
        plug_valid = 1'b1; plug_hot = hot; plug_slot = s;
        @(negedge clk);
        plug_valid = 1'b0;
        check(32'(hp_event), 32'(hot), tag);
        @(negedge clk);
        check(32'(hp_event), 32'd0, tag);
    endtask

    task automatic scan_cmd(input int exp_cycles, input string tag);
        int cnt = 0;
        bus_write(2'd1, 4'b0010, 32'h0000_0000);
        while (busy && cnt < 100) begin
            cnt++;
            @(negedge clk);
        end
        check(32'(cnt), 32'(exp_cycles), tag);
    endtask

    task automatic report;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            report();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(32'(busy), 32'd0, "R1 busy");
        check(32'(hp_event), 32'd0, "R1 event");
        bus_read(2'd1, 32'h0, "R1 flags");
        bus_read(2'd2, 32'h0, "R1 R8 data selector 0");
        bus_read(2'd0, 32'h0, "R2 selector reads 0");

        plug(3'd2, 1'b0, "R4 cold no event");
        bus_write(2'd0, 4'hf, 32'd2);
        bus_read(2'd1, 32'h1, "R2 R4 cold present only");

        plug(3'd5, 1'b1, "R4 hot event");
        bus_write(2'd0, 4'hf, 32'd5);
        bus_read(2'd1, 32'h3, "R4 hot flags");
        plug(3'd5, 1'b1, "R4 repeat event");

        bus_write(2'd1, 4'b0001, 32'h1);
        bus_read(2'd1, 32'h3, "R3 zero bit no effect");
        bus_write(2'd1, 4'b0001, 32'h2);
        bus_read(2'd1, 32'h1, "R3 clear");

        plug(3'd1, 1'b1, "R4 hot 1");
        plug(3'd6, 1'b1, "R4 hot 6");
        bus_write(2'd0, 4'hf, 32'd3);
        scan_cmd(4, "R5 busy 3..6");
        bus_read(2'd2, 32'd6, "R5 R8 found 6");

        bus_write(2'd1, 4'b0001, 32'h2);
        scan_cmd(4, "R5 wrap busy");
        bus_read(2'd2, 32'd1, "R5 wrap found 1");

        bus_write(2'd1, 4'b0001, 32'h2);
        scan_cmd(N_SLOTS, "R6 full lap");
        bus_read(2'd2, 32'd1, "R6 selector kept");

        bus_write(2'd1, 4'b0010, 32'h0000_0100);
        check(32'(busy), 32'd0, "R7 no scan");
        bus_read(2'd2, 32'd1, "R7 command kept");

        bus_write(2'd0, 4'hf, 32'd9);
        bus_read(2'd1, 32'h0, "R9 flags 0");
        bus_read(2'd2, 32'h0, "R9 data 0");
        bus_write(2'd1, 4'b0010, 32'h0);
        check(32'(busy), 32'd0, "R9 command ignored");
        plug(3'd1, 1'b1, "R4 hot 1 again");
        bus_write(2'd1, 4'b0001, 32'h2);
        bus_write(2'd0, 4'hf, 32'd1);
        bus_read(2'd1, 32'h3, "R9 clear ignored");

        bus_write(2'd0, 4'b0001, 32'h5);
        bus_read(2'd1, 32'h1, "R11 lane 0");
        bus_write(2'd0, 4'b0010, 32'h0000_0100);
        bus_read(2'd1, 32'h0, "R11 lane 1 set");
        bus_write(2'd0, 4'b0010, 32'h0);
        bus_read(2'd2, 32'd5, "R11 lane 1 cleared");

        bus_write(2'd0, 4'hf, 32'd1);
        bus_write(2'd1, 4'b0001, 32'h2);
        plug(3'd4, 1'b1, "R4 hot 4");
        bus_write(2'd0, 4'hf, 32'd0);
        bus_write(2'd1, 4'b0010, 32'h0);
        check(32'(busy), 32'd1, "R10 busy");
        bus_write(2'd0, 4'hf, 32'd7);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b0; bus_word = 2'd2;
        @(negedge clk);
        bus_req = 1'b0;
        while (busy) @(negedge clk);
        bus_read(2'd2, 32'd4, "R10 R5 selector write ignored");

        repeat (3) @(negedge clk);
        check(32'(exp_q.size()), 32'd0, "R2 all reads answered");
        done = 1'b1;
        report();
    end
endmodule